// File: doc/BRIEF.md
# Program Counter Breakpoint and Tracepoint Watcher

This block watches the program counters of several sequencer state machines. Each machine has two masks with one bit per instruction memory address. A breakpoint mask bit stops the whole sequencer group: when the machine's program counter moves onto a marked address, a shared clock mode register switches into single-step mode. In single-step mode the machines advance only on cycles in which the host raises a step request. The host can write the mode register to return the group to free-run, or to force single-step itself.

A tracepoint mask bit never touches the clock mode. When a machine moves onto a traced address, the block emits a one-cycle trace event that carries the machine number and the address. Tracepoints work in free-run and in single-step mode. Each machine owns one slot that holds its unreported event. A fixed-priority drain reports the slots one per cycle, lowest machine number first.

A hit counts only when the program counter takes a new value. A machine that stays on a marked address raises nothing more. The host writes a whole mask word at a time and can read any mask back through a combinational read port.

Top module: `bkpt_trace_unit`

## Requirements
- R1: After synchronous reset, every mask reads zero, the mode is free-run (`step_mode_o` = 0), all advance enables are high and `trc_valid_o` is low.
- R2: A mask write replaces the whole selected word from the next cycle on (`mask_wr_trace_i` = 0 selects the breakpoint mask, 1 the tracepoint mask). Bit n stands for instruction address n, so bit 0 is address 0. Writing a 0 bit removes that mark.
- R3: When a machine's program counter changes to an address whose breakpoint bit is set, `step_mode_o` reads 1 from the following cycle.
- R4: A program counter that keeps its value produces no breakpoint hit and no trace event. This includes the value it holds when reset is released.
- R5: When a program counter changes to a traced address, `trc_valid_o` pulses for one cycle, two cycles after the change, if no lower-numbered machine is waiting. The pulse carries the machine number on `trc_sm_o` and the address on `trc_addr_o`. The mode does not change.
- R6: Tracepoint hits are reported in single-step mode just as in free-run.
- R7: Trace hits that arrive in the same cycle are reported on consecutive cycles in ascending machine order.
- R8: In free-run every bit of `adv_en_o` is 1. In single-step mode every bit equals `step_req_i` in the same cycle.
- R9: A mode write with `mode_wr_step_i` = 0 returns the group to free-run on the next cycle. A breakpoint hit in the same cycle takes precedence and the mode becomes single-step.
- R10: A trace hit on a machine whose earlier event is still unreported is discarded. The earlier address is the one reported.
- R11: Each machine's breakpoint and tracepoint masks act independently. A breakpoint-only address raises no trace event, and a trace-only address leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | NUM_SM*ADDR_W | Program counters, machine k in bits [k*ADDR_W +: ADDR_W] |
| mask_wr_en_i | input | 1 | Mask write strobe |
| mask_wr_sel_i | input | SM_W | Machine whose mask is written |
| mask_wr_trace_i | input | 1 | 0 writes the breakpoint mask, 1 the tracepoint mask |
| mask_wr_data_i | input | MASK_W | New mask word |
| mask_rd_sel_i | input | SM_W | Machine whose mask is read |
| mask_rd_trace_i | input | 1 | 0 reads the breakpoint mask, 1 the tracepoint mask |
| mask_rd_data_o | output | MASK_W | Selected mask word |
| mode_wr_en_i | input | 1 | Mode register write strobe |
| mode_wr_step_i | input | 1 | Value written: 1 single-step, 0 free-run |
| step_req_i | input | 1 | Host step request, used in single-step mode |
| step_mode_o | output | 1 | 1 while the group is in single-step mode |
| adv_en_o | output | NUM_SM | Per-machine advance enable |
| trc_valid_o | output | 1 | Trace event valid, one cycle per event |
| trc_sm_o | output | SM_W | Machine number of the trace event |
| trc_addr_o | output | ADDR_W | Address of the trace event |

## Verification
The bench runs all four machines onto traced addresses in the same cycle. A drain that is not in priority order, or one that reports several events at once, would show the wrong machine numbers or lose events. It moves one machine again while its slot is still waiting. A design that overwrote the slot would report the newer address, or would report that machine twice. It parks a machine on a breakpoint address after the host has restored free-run. A level-triggered compare would fall straight back into single-step. It also writes free-run in the same cycle as a breakpoint hit, where the wrong priority leaves the group running. Random phases compare every cycle against a reference model, in both modes and while masks are being rewritten.

// File: rtl/bpt_pkg.sv
// Shared encodings for the breakpoint and tracepoint watcher.
// Assumes: nothing beyond the encodings themselves.
package bpt_pkg;
    typedef enum logic {
        MASK_BREAK = 1'b0,
        MASK_TRACE = 1'b1
    } mask_kind_e;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_STEP = 1'b1
    } clk_mode_e;
endpackage

// File: rtl/bpt_mask_bank.sv
// Holds one breakpoint and one tracepoint mask per machine.
// Whole-word writes take effect at the next edge.
// Assumes: wr_sel_i values at or above NUM_SM are ignored.
module bpt_mask_bank
    import bpt_pkg::*;
#(
    parameter int NUM_SM = 4,
    parameter int MASK_W = 32,
    parameter int SM_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [SM_W-1:0]          wr_sel_i,
    input  logic                     wr_trace_i,
    input  logic [MASK_W-1:0]        wr_data_i,
    input  logic [SM_W-1:0]          rd_sel_i,
    input  logic                     rd_trace_i,
    output logic [MASK_W-1:0]        rd_data_o,
    output logic [NUM_SM*MASK_W-1:0] brk_mask_o,
    output logic [NUM_SM*MASK_W-1:0] trc_mask_o
);
    logic [MASK_W-1:0] brk_q [NUM_SM];
    logic [MASK_W-1:0] trc_q [NUM_SM];
    mask_kind_e        wr_kind;
    mask_kind_e        rd_kind;

    assign wr_kind = mask_kind_e'(wr_trace_i);
    assign rd_kind = mask_kind_e'(rd_trace_i);

    // Mask storage: reset clear, whole-word replace on a matching write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SM; i++) begin
            if (!rst_n) begin
                brk_q[i] <= '0;
                trc_q[i] <= '0;
            end else if (wr_en_i && wr_sel_i == SM_W'(i)) begin
                if (wr_kind == MASK_TRACE) trc_q[i] <= wr_data_i;
                else                       brk_q[i] <= wr_data_i;
            end
        end
    end

    // Host read port: the selected word, combinationally.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_SM; i++) begin
            if (rd_sel_i == SM_W'(i))
                rd_data_o = (rd_kind == MASK_TRACE) ? trc_q[i] : brk_q[i];
        end
    end

    for (genvar g = 0; g < NUM_SM; g++) begin : g_flat
        assign brk_mask_o[g*MASK_W +: MASK_W] = brk_q[g];
        assign trc_mask_o[g*MASK_W +: MASK_W] = trc_q[g];

        // R2: a write to this machine's breakpoint word is visible next cycle
        p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_sel_i == SM_W'(g) && !wr_trace_i)
            |=> brk_mask_o[g*MASK_W +: MASK_W] == $past(wr_data_i));
    end
endmodule

// File: rtl/bpt_pc_watch.sv
// Compares one machine's program counter with its two masks.
// A hit needs the counter to differ from its value one cycle earlier.
// Assumes: the counter is synchronous to clk. The value held during
// reset counts as the previous value.
module bpt_pc_watch #(
    parameter int ADDR_W = 5,
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [MASK_W-1:0] brk_mask_i,
    input  logic [MASK_W-1:0] trc_mask_i,
    output logic              brk_hit_o,
    output logic              trc_hit_o
);
    logic [ADDR_W-1:0] prev_q;
    logic              moved;

    // Previous counter value, captured in reset too so release is not a move.
    always_ff @(posedge clk) begin
        prev_q <= pc_i;
    end

    assign moved     = (pc_i != prev_q);
    assign brk_hit_o = moved && brk_mask_i[pc_i];
    assign trc_hit_o = moved && trc_mask_i[pc_i];

    // R4: a counter that holds still raises no hit of either kind
    p_parked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pc_i) |-> !(brk_hit_o || trc_hit_o));
endmodule

// File: rtl/bpt_clk_mode.sv
// Shared clock mode register and per-machine advance enables.
// A breakpoint hit outranks a host write in the same cycle.
// Assumes: step_req_i is a level sampled every cycle in single-step mode.
module bpt_clk_mode
    import bpt_pkg::*;
#(
    parameter int NUM_SM = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_any_i,
    input  logic              mode_wr_en_i,
    input  logic              mode_wr_step_i,
    input  logic              step_req_i,
    output logic              step_mode_o,
    output logic [NUM_SM-1:0] adv_en_o
);
    clk_mode_e mode_q;

    // Mode register: breakpoint forces single-step, otherwise a host write applies.
    always_ff @(posedge clk) begin
        if (!rst_n)               mode_q <= MODE_RUN;
        else if (brk_any_i)       mode_q <= MODE_STEP;
        else if (mode_wr_en_i)    mode_q <= clk_mode_e'(mode_wr_step_i);
    end

    assign step_mode_o = (mode_q == MODE_STEP);
    assign adv_en_o    = step_mode_o ? {NUM_SM{step_req_i}} : {NUM_SM{1'b1}};

    // R3: any breakpoint hit leads to single-step on the next cycle
    p_break_to_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_any_i |=> step_mode_o);
    // R9: a host write to free-run with no competing hit takes effect
    p_host_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_en_i && !mode_wr_step_i && !brk_any_i) |=> !step_mode_o);
    // R8: free-run enables every machine
    p_run_all_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_mode_o |-> (&adv_en_o));
    // R8: single-step without a request holds every machine
    p_step_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_mode_o && !step_req_i) |-> (adv_en_o == '0));
endmodule

// File: rtl/bpt_trace_queue.sv
// One pending slot per machine and a fixed-priority drain that reports
// the lowest waiting machine each cycle through a registered output.
// Assumes: a new hit on a machine whose slot still waits is dropped.
// A slot that drains in the same cycle may refill.
module bpt_trace_queue #(
    parameter int NUM_SM = 4,
    parameter int ADDR_W = 5,
    parameter int SM_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SM-1:0]        hit_i,
    input  logic [NUM_SM*ADDR_W-1:0] addr_i,
    output logic                     valid_o,
    output logic [SM_W-1:0]          sm_o,
    output logic [ADDR_W-1:0]        addr_o
);
    logic [NUM_SM-1:0] pend_q;
    logic [ADDR_W-1:0] slot_q [NUM_SM];
    logic [NUM_SM-1:0] grant;
    logic [NUM_SM-1:0] keep;
    logic [SM_W-1:0]   gsel;

    // Fixed priority: the lowest-numbered waiting slot wins.
    always_comb begin
        grant = '0;
        gsel  = '0;
        for (int i = NUM_SM - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                gsel     = SM_W'(i);
            end
        end
    end

    assign keep = pend_q & ~grant;

    // Slot state: drop the granted slot and accept hits into free slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < NUM_SM; i++) slot_q[i] <= '0;
        end else begin
            pend_q <= keep | hit_i;
            for (int i = 0; i < NUM_SM; i++) begin
                if (hit_i[i] && !keep[i]) slot_q[i] <= addr_i[i*ADDR_W +: ADDR_W];
            end
        end
    end

    // Output register: one event per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            sm_o    <= '0;
            addr_o  <= '0;
        end else begin
            valid_o <= |pend_q;
            sm_o    <= gsel;
            addr_o  <= slot_q[gsel];
        end
    end

    // R7: a waiting slot always yields an event on the next cycle
    p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q) |=> valid_o);

    for (genvar g = 0; g < NUM_SM; g++) begin : g_chk
        // R10: a hit on a free slot is never lost
        p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i[g] && !pend_q[g]) |=> pend_q[g]);
    end
endmodule

// File: rtl/bkpt_trace_unit.sv
// Top of the breakpoint and tracepoint watcher: mask bank, one counter
// watcher per machine, shared mode register and trace drain.
// Assumes: all program counters are synchronous to clk.
module bkpt_trace_unit #(
    parameter int NUM_SM = 4,
    parameter int ADDR_W = 5,
    localparam int MASK_W = 1 << ADDR_W,
    localparam int SM_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SM*ADDR_W-1:0] pc_i,
    input  logic                     mask_wr_en_i,
    input  logic [SM_W-1:0]          mask_wr_sel_i,
    input  logic                     mask_wr_trace_i,
    input  logic [MASK_W-1:0]        mask_wr_data_i,
    input  logic [SM_W-1:0]          mask_rd_sel_i,
    input  logic                     mask_rd_trace_i,
    output logic [MASK_W-1:0]        mask_rd_data_o,
    input  logic                     mode_wr_en_i,
    input  logic                     mode_wr_step_i,
    input  logic                     step_req_i,
    output logic                     step_mode_o,
    output logic [NUM_SM-1:0]        adv_en_o,
    output logic                     trc_valid_o,
    output logic [SM_W-1:0]          trc_sm_o,
    output logic [ADDR_W-1:0]        trc_addr_o
);
    logic [NUM_SM*MASK_W-1:0] brk_mask;
    logic [NUM_SM*MASK_W-1:0] trc_mask;
    logic [NUM_SM-1:0]        brk_hit;
    logic [NUM_SM-1:0]        trc_hit;

    bpt_mask_bank #(.NUM_SM(NUM_SM), .MASK_W(MASK_W), .SM_W(SM_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (mask_wr_en_i),
        .wr_sel_i   (mask_wr_sel_i),
        .wr_trace_i (mask_wr_trace_i),
        .wr_data_i  (mask_wr_data_i),
        .rd_sel_i   (mask_rd_sel_i),
        .rd_trace_i (mask_rd_trace_i),
        .rd_data_o  (mask_rd_data_o),
        .brk_mask_o (brk_mask),
        .trc_mask_o (trc_mask)
    );

    for (genvar g = 0; g < NUM_SM; g++) begin : g_watch
        bpt_pc_watch #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_watch (
            .clk        (clk),
            .rst_n      (rst_n),
            .pc_i       (pc_i[g*ADDR_W +: ADDR_W]),
            .brk_mask_i (brk_mask[g*MASK_W +: MASK_W]),
            .trc_mask_i (trc_mask[g*MASK_W +: MASK_W]),
            .brk_hit_o  (brk_hit[g]),
            .trc_hit_o  (trc_hit[g])
        );
    end

    bpt_clk_mode #(.NUM_SM(NUM_SM)) u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .brk_any_i      (|brk_hit),
        .mode_wr_en_i   (mode_wr_en_i),
        .mode_wr_step_i (mode_wr_step_i),
        .step_req_i     (step_req_i),
        .step_mode_o    (step_mode_o),
        .adv_en_o       (adv_en_o)
    );

    bpt_trace_queue #(.NUM_SM(NUM_SM), .ADDR_W(ADDR_W), .SM_W(SM_W)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (trc_hit),
        .addr_i  (pc_i),
        .valid_o (trc_valid_o),
        .sm_o    (trc_sm_o),
        .addr_o  (trc_addr_o)
    );
endmodule

// File: tb/sim_bkpt_trace_unit.sv
module sim_bkpt_trace_unit;
    localparam int NUM_SM = 4;
    localparam int ADDR_W = 5;
    localparam int MASK_W = 32;
    localparam int SM_W   = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_SM*ADDR_W-1:0] pc_i;
    logic [ADDR_W-1:0]        pcs [NUM_SM];
    logic                     mask_wr_en = 1'b0;
    logic [SM_W-1:0]          mask_wr_sel = '0;
    logic                     mask_wr_trace = 1'b0;
    logic [MASK_W-1:0]        mask_wr_data = '0;
    logic [SM_W-1:0]          mask_rd_sel = '0;
    logic                     mask_rd_trace = 1'b0;
    logic [MASK_W-1:0]        mask_rd_data;
    logic                     mode_wr_en = 1'b0;
    logic                     mode_wr_step = 1'b0;
    logic                     step_req = 1'b0;
    logic                     step_mode;
    logic [NUM_SM-1:0]        adv_en;
    logic                     trc_valid;
    logic [SM_W-1:0]          trc_sm;
    logic [ADDR_W-1:0]        trc_addr;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [MASK_W-1:0] m_brk [NUM_SM];
    logic [MASK_W-1:0] m_trc [NUM_SM];
    logic [ADDR_W-1:0] m_prev [NUM_SM];
    logic [ADDR_W-1:0] m_slot [NUM_SM];
    bit   [NUM_SM-1:0] m_pend = '0;
    bit                m_step = 1'b0;
    bit                m_v = 1'b0;
    int                m_sm = 0;
    logic [ADDR_W-1:0] m_addr = '0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NUM_SM; i++) pc_i[i*ADDR_W +: ADDR_W] = pcs[i];
    end

    bkpt_trace_unit #(.NUM_SM(NUM_SM), .ADDR_W(ADDR_W)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .pc_i            (pc_i),
        .mask_wr_en_i    (mask_wr_en),
        .mask_wr_sel_i   (mask_wr_sel),
        .mask_wr_trace_i (mask_wr_trace),
        .mask_wr_data_i  (mask_wr_data),
        .mask_rd_sel_i   (mask_rd_sel),
        .mask_rd_trace_i (mask_rd_trace),
        .mask_rd_data_o  (mask_rd_data),
        .mode_wr_en_i    (mode_wr_en),
        .mode_wr_step_i  (mode_wr_step),
        .step_req_i      (step_req),
        .step_mode_o     (step_mode),
        .adv_en_o        (adv_en),
        .trc_valid_o     (trc_valid),
        .trc_sm_o        (trc_sm),
        .trc_addr_o      (trc_addr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Model of one clock edge, computed from the requirements.
    task automatic model_edge();
        bit [NUM_SM-1:0] hit_b, hit_t, keep;
        int gi;
        if (!rst_n) begin
            for (int i = 0; i < NUM_SM; i++) begin
                m_brk[i] = '0; m_trc[i] = '0; m_slot[i] = '0; m_prev[i] = pcs[i];
            end
            m_pend = '0; m_step = 1'b0; m_v = 1'b0;
            return;
        end
        for (int i = 0; i < NUM_SM; i++) begin
            hit_b[i] = (pcs[i] != m_prev[i]) && m_brk[i][pcs[i]];
            hit_t[i] = (pcs[i] != m_prev[i]) && m_trc[i][pcs[i]];
        end
        gi = -1;
        for (int i = 0; i < NUM_SM; i++) if (m_pend[i] && gi < 0) gi = i;
        m_v = (gi >= 0);
        keep = m_pend;
        if (gi >= 0) begin
            m_sm = gi; m_addr = m_slot[gi]; keep[gi] = 1'b0;
        end
        for (int i = 0; i < NUM_SM; i++) if (hit_t[i] && !keep[i]) m_slot[i] = pcs[i];
        m_pend = keep | hit_t;
        if (|hit_b) m_step = 1'b1;
        else if (mode_wr_en) m_step = mode_wr_step;
        if (mask_wr_en) begin
            if (mask_wr_trace) m_trc[mask_wr_sel] = mask_wr_data;
            else               m_brk[mask_wr_sel] = mask_wr_data;
        end
        for (int i = 0; i < NUM_SM; i++) m_prev[i] = pcs[i];
    endtask

    // One cycle: check combinational outputs, take the edge, check registered outputs.
    task automatic tick();
        #1;
        if (rst_n) begin
            chk("R8 adv_en", 32'(adv_en), m_step ? {28'd0, {NUM_SM{step_req}}} : 32'hF);
            chk("R2 readback", mask_rd_data,
                mask_rd_trace ? m_trc[mask_rd_sel] : m_brk[mask_rd_sel]);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R3 mode", 32'(step_mode), 32'(m_step));
        chk("R5 trace valid", 32'(trc_valid), 32'(m_v));
        if (m_v) begin
            chk("R7 trace machine", 32'(trc_sm), 32'(m_sm));
            chk("R5 trace addr", 32'(trc_addr), 32'(m_addr));
        end
    endtask

    task automatic wr_mask(int sm, bit trace, logic [31:0] data);
        mask_wr_en = 1'b1; mask_wr_sel = SM_W'(sm); mask_wr_trace = trace; mask_wr_data = data;
        tick();
        mask_wr_en = 1'b0;
    endtask

    task automatic rd_mask(string req, int sm, bit trace, logic [31:0] exp);
        mask_rd_sel = SM_W'(sm); mask_rd_trace = trace;
        #1;
        chk(req, mask_rd_data, exp);
    endtask

    task automatic expect_event(string req, int sm, int addr);
        tick();
        chk(req, 32'(trc_valid), 32'd1);
        chk(req, 32'(trc_sm), 32'(sm));
        chk(req, 32'(trc_addr), 32'(addr));
    endtask

    // Watchdog
    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_SM; i++) pcs[i] = '0;
        @(negedge clk);
        tick(); tick(); tick();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 mode", 32'(step_mode), 32'd0);
        chk("R1 trace", 32'(trc_valid), 32'd0);
        #1 chk("R1 adv", 32'(adv_en), 32'hF);
        for (int i = 0; i < NUM_SM; i++) begin
            rd_mask("R1 brk mask", i, 1'b0, 32'd0);
            rd_mask("R1 trc mask", i, 1'b1, 32'd0);
        end

        // R2: whole-word write, bit n is address n, zero clears
        wr_mask(2, 1'b0, 32'h8000_0001);
        rd_mask("R2 write", 2, 1'b0, 32'h8000_0001);
        rd_mask("R2 other kind untouched", 2, 1'b1, 32'd0);
        wr_mask(2, 1'b0, 32'h0);
        rd_mask("R2 clear", 2, 1'b0, 32'd0);

        // Mask setup for the directed cases
        wr_mask(0, 1'b1, (32'd1 << 7) | (32'd1 << 20) | (32'd1 << 21));
        wr_mask(1, 1'b1, (32'd1 << 20) | (32'd1 << 21));
        wr_mask(2, 1'b1, (32'd1 << 20) | (32'd1 << 21));
        wr_mask(3, 1'b1, (32'd1 << 20) | (32'd1 << 21) | (32'd1 << 22));
        wr_mask(1, 1'b0, (32'd1 << 9) | (32'd1 << 12) | 32'd1);

        // R4: address 0 is marked for machine 1 but held since reset: no hit
        tick(); tick();
        chk("R4 held since reset", 32'(step_mode), 32'd0);

        // R5 and R11: trace-only hit, mode untouched, single pulse
        pcs[0] = 5'd7;
        tick();
        chk("R5 no event yet", 32'(trc_valid), 32'd0);
        expect_event("R5 event", 0, 7);
        chk("R11 trace keeps mode", 32'(step_mode), 32'd0);
        tick();
        chk("R5 single pulse", 32'(trc_valid), 32'd0);

        // R3 and R11: breakpoint-only hit switches mode, no trace event
        pcs[1] = 5'd9;
        tick();
        chk("R3 break to step", 32'(step_mode), 32'd1);
        tick();
        chk("R11 break gives no trace", 32'(trc_valid), 32'd0);

        // R8: step gating
        step_req = 1'b0;
        #1 chk("R8 held", 32'(adv_en), 32'h0);
        step_req = 1'b1;
        #1 chk("R8 step", 32'(adv_en), 32'hF);
        step_req = 1'b0;

        // R6: trace works in single-step mode
        pcs[0] = 5'd3;
        tick();
        pcs[0] = 5'd7;
        tick();
        expect_event("R6 trace in step mode", 0, 7);

        // R9 and R4: host returns to run; parked machine does not re-break
        mode_wr_en = 1'b1; mode_wr_step = 1'b0;
        tick();
        mode_wr_en = 1'b0;
        chk("R9 back to run", 32'(step_mode), 32'd0);
        tick(); tick(); tick();
        chk("R4 parked no retrigger", 32'(step_mode), 32'd0);

        // R9: breakpoint beats a same-cycle run write
        pcs[1] = 5'd12;
        mode_wr_en = 1'b1; mode_wr_step = 1'b0;
        tick();
        mode_wr_en = 1'b0;
        chk("R9 break wins", 32'(step_mode), 32'd1);
        mode_wr_en = 1'b1;
        tick();
        mode_wr_en = 1'b0;

        // R7: simultaneous hits drain in machine order
        for (int i = 0; i < NUM_SM; i++) pcs[i] = 5'd20;
        tick();
        for (int i = 0; i < NUM_SM; i++) expect_event("R7 order", i, 20);
        tick();
        chk("R7 drained", 32'(trc_valid), 32'd0);

        // R10: second hit on a waiting slot is dropped
        for (int i = 0; i < NUM_SM; i++) pcs[i] = 5'd21;
        tick();
        pcs[3] = 5'd22;
        expect_event("R10 first", 0, 21);
        expect_event("R10 second", 1, 21);
        expect_event("R10 third", 2, 21);
        expect_event("R10 keeps old addr", 3, 21);
        tick();
        chk("R10 dropped hit", 32'(trc_valid), 32'd0);

        // Random phase against the model
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NUM_SM; i++)
                if ($urandom_range(3) == 0) pcs[i] = ADDR_W'($urandom);
            mask_wr_en    = ($urandom_range(15) == 0);
            mask_wr_sel   = SM_W'($urandom);
            mask_wr_trace = 1'($urandom);
            mask_wr_data  = $urandom & $urandom;
            mode_wr_en    = ($urandom_range(11) == 0);
            mode_wr_step  = 1'($urandom);
            step_req      = 1'($urandom);
            mask_rd_sel   = SM_W'($urandom);
            mask_rd_trace = 1'($urandom);
            tick();
        end
        mask_wr_en = 1'b0;
        mode_wr_en = 1'b0;

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule